// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbiter

A synchronous two-port word memory in which a left port and a right port each read or write any location in the same clock cycle. Each port carries an enable, a write strobe, a read (output) enable, two lane selects for the upper and lower halves of the word, an address and write data. A read issued in one cycle returns its word, a valid pulse and a contention flag after the next rising clock edge.

When both ports are enabled on the same address, an arbiter grants the location to one port and raises busy to the other. The port that was already on that address keeps it. When both arrive in the same cycle, the left port wins. The grant lasts until the winner leaves the address or drops its enable. A losing write is discarded. A losing read still returns the stored word, with the contention flag set.

A mode strap chooses the busy source. In master mode the block's own arbitration drives the busy outputs, and the busy inputs have no effect. In slave mode the busy outputs stay low and each port is blocked by its busy input instead, so that several devices can be put side by side to widen the word. Bus timing, power-down and three-state pads are not modelled.

Top module: `dpram_arb`

## Requirements
- R1: While `rst_n` is low and at the first clock after it rises, `l_rvalid`, `r_rvalid`, `l_conflict` and `r_conflict` are 0, `l_rdata` and `r_rdata` are 0, and with both enables low both busy outputs are 0.
- R2: A port reads only when its enable and read enable are high and its write strobe is low. Its `*_rvalid` is then 1 after the next rising edge, with the word stored before that edge. Without read enable no valid pulse appears.
- R3: Lane select `*_hi` covers data bits [DATA_W-1:DATA_W/2] and `*_lo` covers bits [DATA_W/2-1:0]. A write changes only the selected lanes. A read returns 0 in every lane that is not selected.
- R4: Busy is raised to a port only while both enables are high and both addresses are equal.
- R5: When both ports start on the same address in the same cycle, the left port is granted and only the right port is busy. Both ports are never busy from arbitration at once.
- R6: When one port was enabled on an address in the previous cycle and the other port joins it, the port that was already there keeps the grant.
- R7: The grant stays with the winner for as long as the match lasts. Once the winner disables or moves, the other port is no longer busy. If the first winner then returns, it counts as the newcomer.
- R8: A write issued by a busy port leaves memory unchanged.
- R9: A read by a busy port returns the stored word, with `*_conflict` set to 1 alongside `*_rvalid`.
- R10: With `master_mode`=1, the busy outputs carry the arbitration result and the busy inputs are ignored. With `master_mode`=0, both busy outputs are 0.
- R11: With `master_mode`=0, a port whose busy input is 1 does not write, and its reads are flagged as contended. Local arbitration does not block it.
- R12: When both ports write the same address in the same cycle without being blocked, the left port's data wins in every lane that both ports selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_mode | input | 1 | 1: own arbitration drives busy; 0: busy taken from inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left write strobe (0 = read) |
| l_oe | input | 1 | Left read enable |
| l_hi | input | 1 | Left upper-lane select |
| l_lo | input | 1 | Left lower-lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_busy_in | input | 1 | Left busy from a master device (slave mode) |
| l_rdata | output | DATA_W | Left read data |
| l_rvalid | output | 1 | Left read data valid |
| l_conflict | output | 1 | Left read was made while busy |
| l_busy_out | output | 1 | Left busy from arbitration (master mode) |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right write strobe (0 = read) |
| r_oe | input | 1 | Right read enable |
| r_hi | input | 1 | Right upper-lane select |
| r_lo | input | 1 | Right lower-lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_busy_in | input | 1 | Right busy from a master device (slave mode) |
| r_rdata | output | DATA_W | Right read data |
| r_rvalid | output | 1 | Right read data valid |
| r_conflict | output | 1 | Right read was made while busy |
| r_busy_out | output | 1 | Right busy from arbitration (master mode) |

## Verification
The arbitration decision and the memory write resolve in the same cycle. Whether a write lands depends on who wins the address in the cycle the write is issued. The bench drives both ports onto one address with writes in the same cycle, both as a fresh tie and with one port already there. It checks the busy outputs one nanosecond after the inputs settle, then reads the location back to confirm that only the granted data was stored. In slave mode it repeats the same-cycle collision with the busy inputs low to check that the left lanes win.

// File: rtl/dpa_pkg.sv
// Shared types for the dual-port contention block.
// Assumes: nothing beyond standard SystemVerilog.
package dpa_pkg;

    // Which port currently holds a contended address.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Per-port access controls, all active high.
    typedef struct packed {
        logic en;
        logic wr;
        logic oe;
        logic hi;
        logic lo;
    } ctl_t;

endpackage

// File: rtl/dpa_arbiter.sv
// Same-address arbiter: decides which port owns a shared address.
// Assumes: inputs are stable around the clock edge; a port is
// "already there" when it was enabled on the same address last cycle.
module dpa_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose
);

    logic              match;
    logic              l_stay, r_stay, win_left;
    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    owner_e            owner_q, owner_d;

    // Detect contention and pick the winner for this cycle.
    always_comb begin
        match  = l_en && r_en && (l_addr == r_addr);
        l_stay = l_en_q && (l_addr_q == l_addr);
        r_stay = r_en_q && (r_addr_q == r_addr);
        unique case (owner_q)
            OWN_LEFT:  win_left = 1'b1;
            OWN_RIGHT: win_left = 1'b0;
            default:   win_left = !(r_stay && !l_stay);
        endcase
        l_lose  = match && !win_left;
        r_lose  = match && win_left;
        owner_d = !match ? OWN_NONE : (win_left ? OWN_LEFT : OWN_RIGHT);
    end

    // Remember the owner and each port's last access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= OWN_NONE;
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            owner_q  <= owner_d;
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_lose && r_lose)); // R5

    AST_HOLD_LEFT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(match) && $past(l_lose) && match) |-> l_lose); // R7

    AST_HOLD_RIGHT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(match) && $past(r_lose) && match) |-> r_lose); // R7

endmodule

// File: rtl/dpa_port.sv
// One access port: builds the lane mask, gates the write with busy,
// and registers read data, valid and the contention flag.
// Assumes: DATA_W is even; mem_word is the stored word before this edge.
module dpa_port
    import dpa_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic              busy,
    input  logic [DATA_W-1:0] mem_word,
    output logic              we,
    output logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              conflict
);

    localparam int LO_W = DATA_W / 2;
    localparam int HI_W = DATA_W - LO_W;

    logic rd;

    // Decode the request and expand lane selects into a bit mask.
    always_comb begin
        lane_mask = {{HI_W{ctl.hi}}, {LO_W{ctl.lo}}};
        we        = ctl.en && ctl.wr && !busy;
        rd        = ctl.en && !ctl.wr && ctl.oe;
    end

    // Capture read results one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rvalid   <= 1'b0;
            conflict <= 1'b0;
        end else begin
            rvalid   <= rd;
            conflict <= rd && busy;
            if (rd) rdata <= mem_word & lane_mask;
        end
    end

    AST_READ_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(ctl.en && ctl.oe && !ctl.wr)); // R2

    AST_CONFLICT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> rvalid); // R9

endmodule

// File: rtl/dpa_store.sv
// Word array with two write ports and two combinational read ports.
// Assumes: a same-address double write merges right first, then left.
module dpa_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic [DATA_W-1:0] l_mask,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_we,
    input  logic [DATA_W-1:0] r_mask,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_word,
    output logic [DATA_W-1:0] r_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] r_new, l_base, l_new;

    // Merge write data lane by lane; left lands on top of right.
    always_comb begin
        l_word = mem[l_addr];
        r_word = mem[r_addr];
        r_new  = (r_word & ~r_mask) | (r_wdata & r_mask);
        l_base = (r_we && (r_addr == l_addr)) ? r_new : l_word;
        l_new  = (l_base & ~l_mask) | (l_wdata & l_mask);
    end

    // Commit the granted writes.
    always_ff @(posedge clk) begin
        if (r_we) mem[r_addr] <= r_new;
        if (l_we) mem[l_addr] <= l_new;
    end

endmodule

// File: rtl/dpram_arb.sv
// Top: dual-port word memory with same-address arbitration and a
// master/slave busy strap for width expansion.
// Assumes: all controls are active high and synchronous to clk.
module dpram_arb
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_oe,
    input  logic              l_hi,
    input  logic              l_lo,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              l_busy_in,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    output logic              l_conflict,
    output logic              l_busy_out,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic              r_oe,
    input  logic              r_hi,
    input  logic              r_lo,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    input  logic              r_busy_in,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    output logic              r_conflict,
    output logic              r_busy_out
);

    logic              l_lose, r_lose, l_busy, r_busy;
    logic              l_we, r_we;
    logic [DATA_W-1:0] l_mask, r_mask, l_word, r_word;
    ctl_t              l_ctl, r_ctl;

    // Bundle controls and select the busy source from the strap.
    always_comb begin
        l_ctl      = '{en: l_en, wr: l_wr, oe: l_oe, hi: l_hi, lo: l_lo};
        r_ctl      = '{en: r_en, wr: r_wr, oe: r_oe, hi: r_hi, lo: r_lo};
        l_busy     = master_mode ? l_lose : l_busy_in;
        r_busy     = master_mode ? r_lose : r_busy_in;
        l_busy_out = master_mode && l_lose;
        r_busy_out = master_mode && r_lose;
    end

    dpa_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .l_en(l_en), .r_en(r_en),
        .l_addr(l_addr), .r_addr(r_addr), .l_lose(l_lose), .r_lose(r_lose)
    );

    dpa_port #(.DATA_W(DATA_W)) u_lport (
        .clk(clk), .rst_n(rst_n), .ctl(l_ctl), .busy(l_busy), .mem_word(l_word),
        .we(l_we), .lane_mask(l_mask), .rdata(l_rdata), .rvalid(l_rvalid),
        .conflict(l_conflict)
    );

    dpa_port #(.DATA_W(DATA_W)) u_rport (
        .clk(clk), .rst_n(rst_n), .ctl(r_ctl), .busy(r_busy), .mem_word(r_word),
        .we(r_we), .lane_mask(r_mask), .rdata(r_rdata), .rvalid(r_rvalid),
        .conflict(r_conflict)
    );

    dpa_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk),
        .l_we(l_we), .l_mask(l_mask), .l_addr(l_addr), .l_wdata(l_wdata),
        .r_we(r_we), .r_mask(r_mask), .r_addr(r_addr), .r_wdata(r_wdata),
        .l_word(l_word), .r_word(r_word)
    );

    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_out || r_busy_out) |-> (l_en && r_en && l_addr == r_addr)); // R4

    AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !((l_busy && l_we) || (r_busy && r_we))); // R8

    AST_SLAVE_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> !(l_busy_out || r_busy_out)); // R10

endmodule

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_en = 0, l_wr = 0, l_oe = 0, l_hi = 0, l_lo = 0, l_busy_in = 0;
    logic          r_en = 0, r_wr = 0, r_oe = 0, r_hi = 0, r_lo = 0, r_busy_in = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_rvalid, r_rvalid, l_conflict, r_conflict, l_busy_out, r_busy_out;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_hi(l_hi), .l_lo(l_lo),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_busy_in(l_busy_in),
        .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_conflict(l_conflict),
        .l_busy_out(l_busy_out),
        .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_hi(r_hi), .r_lo(r_lo),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_busy_in(r_busy_in),
        .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_conflict(r_conflict),
        .r_busy_out(r_busy_out)
    );

    // {addr, wdata, write lanes {hi,lo}, read lanes {hi,lo}, expected}
    localparam logic [43:0] VEC [0:6] = '{
        {8'h10, 16'hA5C3, 2'b11, 2'b11, 16'hA5C3},
        {8'h11, 16'hA5C3, 2'b10, 2'b11, 16'hA500},
        {8'h12, 16'hA5C3, 2'b01, 2'b11, 16'h00C3},
        {8'h13, 16'hBEEF, 2'b11, 2'b10, 16'hBE00},
        {8'h14, 16'hBEEF, 2'b11, 2'b01, 16'h00EF},
        {8'hFF, 16'h1234, 2'b00, 2'b11, 16'h0000},
        {8'h00, 16'h7E81, 2'b10, 2'b10, 16'h7E00}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic lset(input bit en, input bit wr, input bit oe, input logic [1:0] ln,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        l_en = en; l_wr = wr; l_oe = oe; {l_hi, l_lo} = ln; l_addr = a; l_wdata = d;
    endtask

    task automatic rset(input bit en, input bit wr, input bit oe, input logic [1:0] ln,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        r_en = en; r_wr = wr; r_oe = oe; {r_hi, r_lo} = ln; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        lset(0, 0, 0, 2'b00, '0, '0);
        rset(0, 0, 0, 2'b00, '0, '0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        // R1: state while reset is held
        chk(!l_rvalid && !r_rvalid && !l_conflict && !r_conflict, "R1 flags in reset",
            {l_rvalid, r_rvalid, l_conflict, r_conflict}, 0);
        rst_n = 1'b1;
        #1;
        chk(!l_busy_out && !r_busy_out, "R1 busy idle", {l_busy_out, r_busy_out}, 0);
        cyc();
        chk(l_rdata == 0 && r_rdata == 0 && !l_rvalid && !r_rvalid, "R1 outputs after reset",
            {l_rdata, r_rdata}, 0);

        // R2/R3 table walk, busy inputs high to show master mode ignores them (R10)
        l_busy_in = 1; r_busy_in = 1;
        for (int i = 0; i < 7; i++) begin
            lset(1, 1, 0, 2'b11, VEC[i][43:36], '0);
            cyc();
            lset(1, 1, 0, VEC[i][19:18], VEC[i][43:36], VEC[i][35:20]);
            cyc();
            lset(0, 0, 0, 2'b00, '0, '0);
            rset(1, 0, 1, VEC[i][17:16], VEC[i][43:36], '0);
            cyc();
            rset(0, 0, 0, 2'b00, '0, '0);
            chk(r_rvalid && !r_conflict && r_rdata == VEC[i][15:0], "R3 lane write/read R2 R10",
                r_rdata, VEC[i][15:0]);
        end
        l_busy_in = 0; r_busy_in = 0;

        // R2: no read enable, no valid pulse
        rset(1, 0, 0, 2'b11, 8'h10, '0);
        cyc();
        chk(!r_rvalid, "R2 read without oe", r_rvalid, 0);
        idle();

        // R4: different addresses, or only one port enabled
        lset(1, 0, 1, 2'b11, 8'h20, '0);
        rset(1, 0, 1, 2'b11, 8'h21, '0);
        #1;
        chk(!l_busy_out && !r_busy_out, "R4 distinct addresses", {l_busy_out, r_busy_out}, 0);
        rset(0, 0, 1, 2'b11, 8'h20, '0);
        #1;
        chk(!l_busy_out && !r_busy_out, "R4 one port disabled", {l_busy_out, r_busy_out}, 0);
        cyc();
        idle();
        cyc();

        // R5: same-cycle tie, both writing
        lset(1, 1, 0, 2'b11, 8'h40, 16'h1111);
        rset(1, 1, 0, 2'b11, 8'h40, 16'h2222);
        #1;
        chk(!l_busy_out && r_busy_out, "R5 tie goes left", {l_busy_out, r_busy_out}, 2'b01);
        cyc();
        idle();
        cyc();
        rset(1, 0, 1, 2'b11, 8'h40, '0);
        cyc();
        chk(r_rvalid && r_rdata == 16'h1111, "R5 R8 winner data stored", r_rdata, 16'h1111);

        // R6: right already on 0x40, left joins with a write
        lset(1, 1, 0, 2'b11, 8'h40, 16'h5555);
        #1;
        chk(l_busy_out && !r_busy_out, "R6 incumbent keeps grant", {l_busy_out, r_busy_out}, 2'b10);
        cyc();
        lset(1, 0, 1, 2'b11, 8'h40, '0);
        #1;
        chk(l_busy_out, "R7 grant held", l_busy_out, 1);
        cyc();
        chk(l_rvalid && l_conflict && l_rdata == 16'h1111, "R8 R9 busy read, write dropped",
            {l_conflict, l_rdata}, {1'b1, 16'h1111});
        rset(0, 0, 0, 2'b00, '0, '0);
        #1;
        chk(!l_busy_out && !r_busy_out, "R7 release on winner leave", {l_busy_out, r_busy_out}, 0);
        cyc();
        chk(l_rvalid && !l_conflict, "R9 no conflict when free", l_conflict, 0);
        rset(1, 0, 1, 2'b11, 8'h40, '0);
        #1;
        chk(r_busy_out && !l_busy_out, "R7 returning port is newcomer", {l_busy_out, r_busy_out}, 2'b01);
        cyc();
        chk(r_conflict && r_rdata == 16'h1111, "R9 right contended read", r_conflict, 1);
        idle();
        cyc();

        // R10/R11: slave mode uses busy inputs
        master_mode = 0;
        l_busy_in = 1; r_busy_in = 0;
        lset(1, 1, 0, 2'b11, 8'h50, 16'hAAAA);
        rset(1, 1, 0, 2'b11, 8'h50, 16'h3333);
        #1;
        chk(!l_busy_out && !r_busy_out, "R10 slave busy outputs low", {l_busy_out, r_busy_out}, 0);
        cyc();
        rset(0, 0, 0, 2'b00, '0, '0);
        lset(1, 0, 1, 2'b11, 8'h50, '0);
        cyc();
        chk(l_rvalid && l_conflict && l_rdata == 16'h3333, "R11 busy input blocks write",
            {l_conflict, l_rdata}, {1'b1, 16'h3333});
        l_busy_in = 0;

        // R12: unblocked same-cycle writes, left lanes win
        lset(1, 1, 0, 2'b11, 8'h51, 16'h0C0C);
        rset(1, 1, 0, 2'b11, 8'h51, 16'hF0F0);
        cyc();
        lset(0, 0, 0, 2'b00, '0, '0);
        rset(1, 0, 1, 2'b11, 8'h51, '0);
        cyc();
        chk(r_rdata == 16'h0C0C, "R12 left wins double write", r_rdata, 16'h0C0C);
        idle();
        cyc();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule